// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Front End

This block is the pin-facing front end of a parallel NOR-style flash model. On every clock it samples the active-low chip-enable, output-enable and write-enable strobes, the active-low hardware reset pin, the width-select pin and the address. It reduces them to one bus operation: read, write, standby, output disable, hardware reset, or an illegal overlap that is treated as no operation. The data bus is split into `dq_i`, `dq_o` and a per-bit `dq_oe` so that the pad tri-state buffers can sit outside the block.

With `word_sel` high, all sixteen data lines carry data. With `word_sel` low, only the low eight lines carry data and the top line, `dq_i[15]`, becomes the byte-within-word address bit. Lines 8 to 15 are then never driven. Reads return a fixed-pattern internal array while the block is in read-array mode. After the first committed write they return the word offered by the downstream state machine on `sm_data`. Writes are captured into a command register and passed downstream as a one-cycle `cmd_valid` pulse. The command register has no array address of its own.

Pins go through one register stage, and the outputs are registered. Every pin change therefore shows at the outputs after the second rising clock edge.

Top module: `flash_bus_front`

## Requirements
- R1: After `rst`, `dq_oe` is 0, `cmd_valid` is 0, `cmd_addr` and `cmd_data` are 0, and `array_mode` is 1 (read-array mode). Reads then return array data without any command being issued.
- R2: A read is chip enable low, output enable low, write enable low-inactive (high) and `hw_reset_n` high. In word mode (`word_sel`=1) it drives `dq_oe`=16'hFFFF. `dq_o` is then the array word at index `addr[ROM_AW-1:0]`, and word i of the array is {i[7:0]^8'hC3, i[7:0]+8'h11}. The output appears two clock edges after the pins.
- R3: A read in byte mode (`word_sel`=0) drives `dq_oe`=16'h00FF and `dq_o[15:8]`=0. `dq_o[7:0]` is the high byte of the addressed word when `dq_i[15]`=1 and the low byte when it is 0.
- R4: With chip enable high (standby), or chip enable low and both output enable and write enable high (output disable), `dq_oe` is 0.
- R5: A write is chip enable and write enable low with output enable high. It commits when write enable or chip enable rises. The commit raises `cmd_valid` for exactly one cycle, two edges after the rise. In word mode it presents `cmd_addr`={1'b0, addr}, `cmd_data`=`dq_i` and `cmd_byte`=0, taken from the last sampled write cycle.
- R6: A write in byte mode commits with `cmd_addr`={addr, dq_i[15]}, `cmd_data`={8'h00, dq_i[7:0]} and `cmd_byte`=1.
- R7: Write enable and output enable both low with chip enable low is no operation. It leaves `dq_oe` at 0 and produces no `cmd_valid`. A write that ends this way is dropped.
- R8: While `hw_reset_n` is low, `dq_oe` is 0. The command register is also cleared, `array_mode` returns to 1, and a pending write is dropped without a `cmd_valid` pulse.
- R9: Each committed write clears `array_mode`. Reads then return `sm_data`, byte-selected as in R3 in byte mode. While `array_mode` is 1, `sm_data` has no effect on `dq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hw_reset_n | input | 1 | Hardware reset pin, active low |
| word_sel | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| addr | input | ADDR_W | Word address |
| dq_i | input | 16 | Data bus in; bit 15 is the byte address bit in byte mode |
| sm_data | input | 16 | Read data from the downstream state machine |
| dq_o | output | 16 | Data bus out |
| dq_oe | output | 16 | Per-bit output enable for the pad buffers |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | ADDR_W+1 | Latched command address |
| cmd_data | output | 16 | Latched command data |
| cmd_byte | output | 1 | Latched command was a byte-mode write |
| array_mode | output | 1 | 1 = read-array mode |

## Verification
The hardest case to reach is a write that is still open when the hardware reset pin drops. The commit logic must not fire when write enable and chip enable later rise. To get there, the stimulus holds a write for two cycles and pulls `hw_reset_n` low while write enable is still asserted. It then releases every strobe in the same cycle as the reset pin. The bench watches that no `cmd_valid` appears and that the command register and mode read as cleared. A similar path covers a write that ends in the illegal overlap: output enable falls while write enable is still low, and the bench confirms that nothing is handed downstream.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  localparam int DQ_W   = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DQ_W / BYTE_W;

  typedef enum logic [2:0] {
    OP_READ,
    OP_WRITE,
    OP_STANDBY,
    OP_OUTDIS,
    OP_RESET,
    OP_NOP
  } bus_op_e;

  // Fixed array pattern: high byte = index ^ C3, low byte = index + 11.
  function automatic logic [DQ_W-1:0] rom_word(input logic [DQ_W-1:0] idx);
    logic [BYTE_W-1:0] b;
    b = idx[BYTE_W-1:0];
    return {b ^ 8'hC3, b + 8'h11};
  endfunction
endpackage

// File: rtl/flash_pin_decode.sv
module flash_pin_decode
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hw_reset_n,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_i,
  output bus_op_e           op,
  output logic              word_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DQ_W-1:0]   dq_q
);
  logic ce_q, oe_q, we_q, hwr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      hwr_q  <= 1'b1;
      word_q <= 1'b1;
      addr_q <= '0;
      dq_q   <= '0;
    end else begin
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      hwr_q  <= hw_reset_n;
      word_q <= word_sel;
      addr_q <= addr;
      dq_q   <= dq_i;
    end
  end

  // Priority: reset pin, then chip enable, then strobe overlap.
  always_comb begin
    if (!hwr_q)              op = OP_RESET;
    else if (ce_q)           op = OP_STANDBY;
    else if (!we_q && !oe_q) op = OP_NOP;
    else if (!we_q)          op = OP_WRITE;
    else if (oe_q)           op = OP_OUTDIS;
    else                     op = OP_READ;
  end
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int ROM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           op,
  input  logic              word_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DQ_W-1:0]   dq_q,
  input  logic              array_mode,
  input  logic [DQ_W-1:0]   sm_data,
  output logic [DQ_W-1:0]   dq_o,
  output logic [DQ_W-1:0]   dq_oe
);
  logic [DQ_W-1:0]   src_word;
  logic [BYTE_W-1:0] pick_byte;
  logic              rd;

  always_comb begin
    src_word  = array_mode ? rom_word(DQ_W'(addr_q[ROM_AW-1:0])) : sm_data;
    pick_byte = dq_q[DQ_W-1] ? src_word[DQ_W-1:BYTE_W] : src_word[BYTE_W-1:0];
    rd        = (op == OP_READ);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              lane_en;
    logic [BYTE_W-1:0] lane_d;

    if (g == 0) begin : g_low
      assign lane_en = rd;
      assign lane_d  = word_q ? src_word[BYTE_W-1:0] : pick_byte;
    end else begin : g_high
      assign lane_en = rd && word_q;
      assign lane_d  = src_word[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        dq_oe[g*BYTE_W +: BYTE_W] <= '0;
        dq_o[g*BYTE_W +: BYTE_W]  <= '0;
      end else begin
        dq_oe[g*BYTE_W +: BYTE_W] <= {BYTE_W{lane_en}};
        dq_o[g*BYTE_W +: BYTE_W]  <= lane_en ? lane_d : '0;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_latch.sv
module flash_cmd_latch
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           op,
  input  logic              word_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DQ_W-1:0]   dq_q,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DQ_W-1:0]   cmd_data,
  output logic              cmd_byte,
  output logic              array_mode
);
  logic            wr_act;
  logic [ADDR_W:0] cap_addr;
  logic [DQ_W-1:0] cap_data;
  logic            cap_byte;

  always_ff @(posedge clk) begin
    if (rst || op == OP_RESET) begin
      wr_act     <= 1'b0;
      cap_addr   <= '0;
      cap_data   <= '0;
      cap_byte   <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      cmd_byte   <= 1'b0;
      array_mode <= 1'b1;
    end else begin
      cmd_valid <= 1'b0;
      if (op == OP_WRITE) begin
        wr_act   <= 1'b1;
        cap_byte <= !word_q;
        if (word_q) begin
          cap_addr <= {1'b0, addr_q};
          cap_data <= dq_q;
        end else begin
          cap_addr <= {addr_q, dq_q[DQ_W-1]};
          cap_data <= {{BYTE_W{1'b0}}, dq_q[BYTE_W-1:0]};
        end
      end else if (wr_act) begin
        wr_act <= 1'b0;
        // Strobe overlap ends the write without a commit.
        if (op != OP_NOP) begin
          cmd_valid  <= 1'b1;
          cmd_addr   <= cap_addr;
          cmd_data   <= cap_data;
          cmd_byte   <= cap_byte;
          array_mode <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int ROM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              hw_reset_n,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_i,
  input  logic [15:0]       sm_data,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data,
  output logic              cmd_byte,
  output logic              array_mode
);
  bus_op_e           op;
  logic              word_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   dq_q;

  flash_pin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_reset_n(hw_reset_n), .word_sel(word_sel), .addr(addr), .dq_i(dq_i),
    .op(op), .word_q(word_q), .addr_q(addr_q), .dq_q(dq_q)
  );

  flash_read_path #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) u_rd (
    .clk(clk), .rst(rst), .op(op), .word_q(word_q), .addr_q(addr_q),
    .dq_q(dq_q), .array_mode(array_mode), .sm_data(sm_data),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  flash_cmd_latch #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .op(op), .word_q(word_q), .addr_q(addr_q),
    .dq_q(dq_q), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte), .array_mode(array_mode)
  );
endmodule

// File: rtl/flash_bus_front_chk.sv
module flash_bus_front_chk #(
  parameter int ADDR_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            ce_n,
  input logic            oe_n,
  input logic            we_n,
  input logic            hw_reset_n,
  input logic [15:0]     dq_oe,
  input logic            cmd_valid,
  input logic [ADDR_W:0] cmd_addr,
  input logic            array_mode
);
  // R2, R3: only the full-word or low-lane enable patterns appear
  p_oe_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == 16'h0000 || dq_oe == 16'h00FF || dq_oe == 16'hFFFF));

  // R4: standby leaves the bus undriven
  p_standby_r4: assert property (@(posedge clk) disable iff (rst)
    (ce_n && hw_reset_n) |-> ##2 (dq_oe == 16'h0000));

  // R5: command strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R7: strobe overlap neither drives nor commits
  p_nop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n && !oe_n && hw_reset_n) |-> ##2 (dq_oe == 16'h0000 && !cmd_valid));

  // R8: hardware reset pin clears outputs and mode
  p_hwreset_r8: assert property (@(posedge clk) disable iff (rst)
    !hw_reset_n |-> ##2 (dq_oe == 16'h0000 && !cmd_valid && array_mode && cmd_addr == '0));

  // R9: a commit leaves read-array mode
  p_valid_mode_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !array_mode);
endmodule

bind flash_bus_front flash_bus_front_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .hw_reset_n(hw_reset_n), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
  .cmd_addr(cmd_addr), .array_mode(array_mode)
);

// File: tb/flash_bus_front_tb_top.sv
`timescale 1ns/100ps
module flash_bus_front_tb_top;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_reset_n = 1'b1;
  logic              word_sel = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       dq_i = '0, sm_data = '0;
  logic [15:0]       dq_o, dq_oe, cmd_data;
  logic              cmd_valid, cmd_byte, array_mode;
  logic [ADDR_W:0]   cmd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_bus_front #(.ADDR_W(ADDR_W), .ROM_AW(8)) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_reset_n(hw_reset_n), .word_sel(word_sel), .addr(addr), .dq_i(dq_i),
    .sm_data(sm_data), .dq_o(dq_o), .dq_oe(dq_oe), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte),
    .array_mode(array_mode)
  );

  function automatic logic [15:0] exp_word(input logic [ADDR_W-1:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {b ^ 8'hC3, b + 8'h11};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic idle_pins();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hw_reset_n = 1'b1; dq_i = '0;
  endtask

  task automatic read_at(input logic ws, input logic [ADDR_W-1:0] a, input logic am1);
    @(negedge clk);
    word_sel = ws; addr = a; dq_i = {am1, 15'h0};
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    chk("R1 dq_oe", 32'(dq_oe), 32'h0);
    chk("R1 cmd_valid", 32'(cmd_valid), 32'h0);
    chk("R1 cmd_addr", 32'(cmd_addr), 32'h0);
    chk("R1 cmd_data", 32'(cmd_data), 32'h0);
    chk("R1 array_mode", 32'(array_mode), 32'h1);
  endtask

  task automatic t_word_read();
    logic [ADDR_W-1:0] list [3] = '{18'd0, 18'd37, 18'd255};
    sm_data = 16'h5A5A;
    foreach (list[i]) begin
      read_at(1'b1, list[i], 1'b0);
      chk("R2 word oe", 32'(dq_oe), 32'hFFFF);
      chk("R2 word data (R9 sm_data ignored)", 32'(dq_o), 32'(exp_word(list[i])));
    end
    idle_pins();
  endtask

  task automatic t_byte_read();
    for (int s = 0; s < 2; s++) begin
      read_at(1'b0, 18'd5, s[0]);
      chk("R3 byte oe", 32'(dq_oe), 32'h00FF);
      chk("R3 byte data", 32'(dq_o),
          32'(s[0] ? {8'h00, exp_word(18'd5)[15:8]} : {8'h00, exp_word(18'd5)[7:0]}));
    end
    idle_pins();
    word_sel = 1'b1;
  endtask

  task automatic t_idle();
    read_at(1'b1, 18'd9, 1'b0);
    @(negedge clk); ce_n = 1'b1;
    settle();
    chk("R4 standby oe", 32'(dq_oe), 32'h0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    settle();
    chk("R4 output disable oe", 32'(dq_oe), 32'h0);
    idle_pins();
  endtask

  task automatic t_nop();
    @(negedge clk);
    word_sel = 1'b1; addr = 18'd12; dq_i = 16'h1234;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); oe_n = 1'b0;
    settle();
    chk("R7 nop oe", 32'(dq_oe), 32'h0);
    chk("R7 nop no strobe", 32'(cmd_valid), 32'h0);
    @(negedge clk); we_n = 1'b1;
    @(posedge clk); #1;
    chk("R7 dropped write no strobe", 32'(cmd_valid), 32'h0);
    @(posedge clk); #1;
    chk("R7 dropped write no strobe", 32'(cmd_valid), 32'h0);
    chk("R7 mode kept", 32'(array_mode), 32'h1);
    idle_pins();
  endtask

  task automatic do_write(input string req, input logic ws, input logic [ADDR_W-1:0] a,
                          input logic [15:0] d, input logic am1, input logic end_ce,
                          input logic [ADDR_W:0] ea, input logic [15:0] ed);
    @(negedge clk);
    word_sel = ws; addr = a;
    dq_i = ws ? d : {am1, 7'h0, d[7:0]};
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    if (end_ce) ce_n = 1'b1; else we_n = 1'b1;
    @(posedge clk); #1;
    chk({req, " no early strobe"}, 32'(cmd_valid), 32'h0);
    @(posedge clk); #1;
    chk({req, " strobe"}, 32'(cmd_valid), 32'h1);
    chk({req, " addr"}, 32'(cmd_addr), 32'(ea));
    chk({req, " data"}, 32'(cmd_data), 32'(ed));
    chk({req, " byte flag"}, 32'(cmd_byte), 32'(!ws));
    chk("R9 mode cleared", 32'(array_mode), 32'h0);
    @(posedge clk); #1;
    chk({req, " strobe one cycle"}, 32'(cmd_valid), 32'h0);
    idle_pins();
  endtask

  task automatic t_word_write();
    do_write("R5", 1'b1, 18'h2AAAA, 16'hC0DE, 1'b0, 1'b0, {1'b0, 18'h2AAAA}, 16'hC0DE);
  endtask

  task automatic t_cmd_read();
    sm_data = 16'hBEEF;
    read_at(1'b1, 18'd3, 1'b0);
    chk("R9 word from sm_data", 32'(dq_o), 32'hBEEF);
    read_at(1'b0, 18'd3, 1'b1);
    chk("R9 byte from sm_data", 32'(dq_o), 32'h00BE);
    chk("R9 byte oe", 32'(dq_oe), 32'h00FF);
    idle_pins();
    word_sel = 1'b1;
  endtask

  task automatic t_byte_write();
    do_write("R6", 1'b0, 18'h00155, 16'hFF7E, 1'b1, 1'b1, {18'h00155, 1'b1}, 16'h007E);
  endtask

  task automatic t_hwreset();
    int seen;
    chk("R8 precondition mode", 32'(array_mode), 32'h0);
    @(negedge clk);
    word_sel = 1'b1; addr = 18'd77; dq_i = 16'h9999;
    ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); hw_reset_n = 1'b0;
    settle();
    chk("R8 reset oe", 32'(dq_oe), 32'h0);
    chk("R8 mode restored", 32'(array_mode), 32'h1);
    chk("R8 cmd_addr cleared", 32'(cmd_addr), 32'h0);
    chk("R8 cmd_data cleared", 32'(cmd_data), 32'h0);
    @(negedge clk);
    hw_reset_n = 1'b1; ce_n = 1'b1; we_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      if (cmd_valid) seen++;
    end
    chk("R8 pending write dropped", 32'(seen), 32'h0);
    read_at(1'b1, 18'd40, 1'b0);
    chk("R8 reads array after reset", 32'(dq_o), 32'(exp_word(18'd40)));
    idle_pins();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_word_read();
    t_byte_read();
    t_idle();
    t_nop();
    t_word_write();
    t_cmd_read();
    t_byte_write();
    t_hwreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule